// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block turns a 16-bit processor address into active-low chip selects for a small computer. The selects go to a lower 32K RAM, an upper 32K RAM, a 32K ROM, and seven 32-byte peripheral windows. The topmost 256 bytes form an I/O page that is cut into eight 32-byte windows. The highest of those windows always selects the ROM, so the interrupt and reset vectors can always be read.

The general upper region, $8000 to $FEFF, holds one of two memories. A control bit driven from a peripheral output pin picks between the ROM and the upper RAM. Firmware boots from ROM, copies itself down, and then sets the bit to map RAM into that region.

The selects are qualified only by the bus-valid phase clock. They are never qualified by the early "address about to be valid" strobe, because that strobe halves the time the memories have to respond. A parameter can also remove the phase qualification. The whole decode is combinational.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While the phase qualifier is active, any address with bit 15 equal to 0 ($0000–$7FFF) drives `ram_lo_n` low and every other select high.
- R2: While qualified, an address in $FF00–$FFDF drives only `io_win_n[k]` low, where k = address bits 7..5 (0 to 6). RAM and ROM selects stay high.
- R3: While qualified, an address in $FFE0–$FFFF drives only `rom_n` low. This holds for either state of the overlay bit and of reset.
- R4: While qualified and out of reset, an address in $8000–$FEFF drives `ram_hi_n` low when `map_ram` = 1, and `rom_n` low when `map_ram` = 0.
- R5: While `rst_n` = 0, the overlay is forced to the ROM setting. With `map_ram` = 1, $8000–$FEFF still drives `rom_n` low.
- R6: For every input combination, at most one select is low.
- R7: With the default `GATE_WITH_E` = 1, all selects are high whenever `e_clk` = 0, whatever the address.
- R8: While qualified, exactly one select is low for every one of the 65,536 addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| e_clk | input | 1 | Bus-valid phase clock that qualifies the selects (high = valid) |
| rst_n | input | 1 | Active-low system reset; forces the ROM overlay |
| map_ram | input | 1 | Overlay control: 1 = upper RAM in $8000–$FEFF, 0 = ROM |
| addr | input | 16 | Processor address |
| ram_lo_n | output | 1 | Active-low select, lower 32K RAM |
| ram_hi_n | output | 1 | Active-low select, upper 32K RAM |
| rom_n | output | 1 | Active-low select, 32K ROM |
| io_win_n | output | 7 | Active-low selects, I/O windows 0..6 ($FF00–$FFDF) |

## Verification
The hardest situation to reach is the seam between regions. Examples are $FEFF against $FF00, $FFDF against $FFE0, and $7FFF against $8000, each of which must be checked while the overlay bit points at RAM and while reset overrides it. The stimulus sweeps every address under each overlay state, so every seam is crossed in every mode. Separate tasks hold `map_ram` high while reset is active, and hold the phase clock low over the same boundary addresses.

// File: rtl/bod_pkg.sv
package bod_pkg;

  typedef enum logic [1:0] {
    REG_LOW_RAM = 2'd0,
    REG_GENERAL = 2'd1,
    REG_IO      = 2'd2,
    REG_VECTOR  = 2'd3
  } region_t;

  typedef struct packed {
    logic ram_lo;
    logic ram_hi;
    logic rom;
  } mem_sel_t;

endpackage

// File: rtl/bod_region_classify.sv
module bod_region_classify
  import bod_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int IO_PAGE_BITS = 8,
  parameter int WIN_BITS     = 5,
  localparam int WIN_IDX_W   = IO_PAGE_BITS - WIN_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  output region_t              region,
  output logic [WIN_IDX_W-1:0] win_idx
);

  function automatic logic in_io_page(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:IO_PAGE_BITS];
  endfunction

  function automatic logic [WIN_IDX_W-1:0] window_of(input logic [ADDR_W-1:0] a);
    return a[IO_PAGE_BITS-1:WIN_BITS];
  endfunction

  logic page_hit;
  assign page_hit = in_io_page(addr);
  assign win_idx  = window_of(addr);

  always_comb begin
    if (!addr[ADDR_W-1])      region = REG_LOW_RAM;
    else if (!page_hit)       region = REG_GENERAL;
    else if (&win_idx)        region = REG_VECTOR;
    else                      region = REG_IO;
  end

  always_comb begin
    if (region == REG_VECTOR)
      assert_vector_top_R3: assert (&addr[ADDR_W-1:WIN_BITS])
        else $error("vector region outside top window");
  end

endmodule

// File: rtl/bod_overlay_ctrl.sv
module bod_overlay_ctrl (
  input  logic rst_n,
  input  logic map_ram,
  output logic ram_mapped
);

  assign ram_mapped = map_ram & rst_n;

  always_comb begin
    if (!rst_n)
      assert_boot_rom_R5: assert (!ram_mapped)
        else $error("RAM overlay active during reset");
  end

endmodule

// File: rtl/bod_select_gen.sv
module bod_select_gen
  import bod_pkg::*;
#(
  parameter int WIN_IDX_W   = 3,
  parameter bit GATE_WITH_E = 1'b1,
  localparam int NUM_WIN    = 2 ** WIN_IDX_W,
  localparam int NUM_IO_OUT = NUM_WIN - 1
) (
  input  region_t              region,
  input  logic [WIN_IDX_W-1:0] win_idx,
  input  logic                 ram_mapped,
  input  logic                 e_clk,
  output mem_sel_t             mem_sel,
  output logic [NUM_IO_OUT-1:0] io_sel,
  output logic                 qual
);

  generate
    if (GATE_WITH_E) begin : g_gate
      assign qual = e_clk;
    end else begin : g_open
      logic unused_e;
      assign unused_e = e_clk;
      assign qual = 1'b1;
    end
  endgenerate

  always_comb begin
    mem_sel = '0;
    if (qual) begin
      unique case (region)
        REG_LOW_RAM: mem_sel.ram_lo = 1'b1;
        REG_GENERAL: begin
          mem_sel.ram_hi = ram_mapped;
          mem_sel.rom    = !ram_mapped;
        end
        REG_VECTOR:  mem_sel.rom = 1'b1;
        default:     mem_sel = '0;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_IO_OUT; k++) begin : g_win
    assign io_sel[k] = qual && (region == REG_IO) && (win_idx == WIN_IDX_W'(k));
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bod_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int IO_PAGE_BITS = 8,
  parameter int WIN_BITS     = 5,
  parameter bit GATE_WITH_E  = 1'b1,
  localparam int WIN_IDX_W   = IO_PAGE_BITS - WIN_BITS,
  localparam int NUM_IO_OUT  = (2 ** WIN_IDX_W) - 1
) (
  input  logic                  e_clk,
  input  logic                  rst_n,
  input  logic                  map_ram,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  ram_lo_n,
  output logic                  ram_hi_n,
  output logic                  rom_n,
  output logic [NUM_IO_OUT-1:0] io_win_n
);

  region_t               region;
  logic [WIN_IDX_W-1:0]  win_idx;
  logic                  ram_mapped;
  logic                  qual;
  mem_sel_t              mem_sel;
  logic [NUM_IO_OUT-1:0] io_sel;

  bod_region_classify #(
    .ADDR_W(ADDR_W), .IO_PAGE_BITS(IO_PAGE_BITS), .WIN_BITS(WIN_BITS)
  ) classify_i (
    .addr(addr), .region(region), .win_idx(win_idx)
  );

  bod_overlay_ctrl overlay_i (
    .rst_n(rst_n), .map_ram(map_ram), .ram_mapped(ram_mapped)
  );

  bod_select_gen #(
    .WIN_IDX_W(WIN_IDX_W), .GATE_WITH_E(GATE_WITH_E)
  ) select_i (
    .region(region), .win_idx(win_idx), .ram_mapped(ram_mapped),
    .e_clk(e_clk), .mem_sel(mem_sel), .io_sel(io_sel), .qual(qual)
  );

  assign ram_lo_n = ~mem_sel.ram_lo;
  assign ram_hi_n = ~mem_sel.ram_hi;
  assign rom_n    = ~mem_sel.rom;
  assign io_win_n = ~io_sel;

  logic [NUM_IO_OUT+2:0] any_low;
  assign any_low = ~{ram_lo_n, ram_hi_n, rom_n, io_win_n};

  always_comb begin
    assert_at_most_one_R6: assert ($onehot0(any_low))
      else $error("multiple selects active");
    if (qual)
      assert_full_decode_R8: assert ($countones(any_low) == 1)
        else $error("qualified cycle without exactly one select");
    if (!qual)
      assert_idle_unqualified_R7: assert (any_low == '0)
        else $error("select active outside valid phase");
    if (qual && !addr[ADDR_W-1])
      assert_low_ram_R1: assert (!ram_lo_n)
        else $error("lower RAM not selected");
    if (qual && region == REG_VECTOR)
      assert_vector_rom_R3: assert (!rom_n)
        else $error("vector window lost ROM");
    if (qual && region == REG_IO)
      assert_io_no_memory_R2: assert (ram_lo_n && ram_hi_n && rom_n)
        else $error("memory selected inside I/O window");
    if (qual && region == REG_GENERAL)
      assert_overlay_choice_R4: assert (ram_hi_n != rom_n)
        else $error("general region select ambiguous");
  end

endmodule

// File: tb/boot_overlay_decoder_tb.sv
module boot_overlay_decoder_tb_top;

  logic        clk = 1'b0;
  logic        e_clk, rst_n, map_ram;
  logic [15:0] addr;
  logic        ram_lo_n, ram_hi_n, rom_n;
  logic [6:0]  io_win_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  boot_overlay_decoder dut_i (
    .e_clk(e_clk), .rst_n(rst_n), .map_ram(map_ram), .addr(addr),
    .ram_lo_n(ram_lo_n), .ram_hi_n(ram_hi_n), .rom_n(rom_n), .io_win_n(io_win_n)
  );

  // Expected active-low vector {ram_lo, ram_hi, rom, io[6:0]} from address ranges.
  function automatic logic [9:0] expect_sel(int a, bit ram, bit e, bit rst_ok);
    logic [9:0] v = 10'h3FF;
    if (!e) return v;
    if (a < 32'h8000)       v[9] = 1'b0;
    else if (a >= 32'hFFE0) v[7] = 1'b0;
    else if (a >= 32'hFF00) v[(a - 32'hFF00) / 32] = 1'b0;
    else if (ram && rst_ok) v[8] = 1'b0;
    else                    v[7] = 1'b0;
    return v;
  endfunction

  function automatic string req_of(int a, bit e, bit rst_ok);
    if (!e)                 return "R7";
    if (a < 32'h8000)       return "R1";
    if (a >= 32'hFFE0)      return "R3";
    if (a >= 32'hFF00)      return "R2";
    if (!rst_ok)            return "R5";
    return "R4";
  endfunction

  task automatic apply_and_check(int a, bit ram, bit e, bit rst_ok, string tag);
    logic [9:0] got, exp;
    addr = a[15:0]; map_ram = ram; e_clk = e; rst_n = rst_ok;
    #5;
    got = {ram_lo_n, ram_hi_n, rom_n, io_win_n};
    exp = expect_sel(a, ram, e, rst_ok);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s/%s addr=%h map=%0b e=%0b rst_n=%0b actual=%b expected=%b",
               tag, req_of(a, e, rst_ok), a[15:0], ram, e, rst_ok, got, exp);
    end
    if (e && $countones(~got) != 1) begin
      checks++; errors++;
      $display("FAIL R8 addr=%h actual_low_count=%0d expected=1", a[15:0], $countones(~got));
    end
    #5;
  endtask

  task automatic t_reset_state();
    // R5: overlay forced to ROM during reset even with map_ram=1
    apply_and_check(32'h0000, 1'b1, 1'b1, 1'b0, "reset_R5");
    apply_and_check(32'h8000, 1'b1, 1'b1, 1'b0, "reset_R5");
    apply_and_check(32'hFEFF, 1'b1, 1'b1, 1'b0, "reset_R5");
    apply_and_check(32'hFFFE, 1'b1, 1'b1, 1'b0, "reset_R3");
    apply_and_check(32'hFF20, 1'b1, 1'b1, 1'b0, "reset_R2");
  endtask

  task automatic t_sweep(bit ram, string tag);
    // R1 R2 R3 R4 R6 R8: every address with the phase active
    for (int a = 0; a < 65536; a++) apply_and_check(a, ram, 1'b1, 1'b1, tag);
  endtask

  task automatic t_seams_unqualified();
    // R7: phase low blanks every select at each boundary
    int pts[10] = '{32'h0000, 32'h7FFF, 32'h8000, 32'hFEFF, 32'hFF00,
                    32'hFF1F, 32'hFFC0, 32'hFFDF, 32'hFFE0, 32'hFFFF};
    foreach (pts[i]) begin
      apply_and_check(pts[i], 1'b0, 1'b0, 1'b1, "idle_R7");
      apply_and_check(pts[i], 1'b1, 1'b0, 1'b1, "idle_R7");
    end
  endtask

  task automatic t_overlay_toggle();
    // R4 then R5: same address, overlay flipped and reset reapplied
    apply_and_check(32'hC123, 1'b0, 1'b1, 1'b1, "toggle_R4");
    apply_and_check(32'hC123, 1'b1, 1'b1, 1'b1, "toggle_R4");
    apply_and_check(32'hC123, 1'b1, 1'b1, 1'b0, "toggle_R5");
    apply_and_check(32'hFFE0, 1'b0, 1'b1, 1'b1, "toggle_R3");
  endtask

  initial begin
    e_clk = 1'b1; rst_n = 1'b0; map_ram = 1'b1; addr = '0;
    @(negedge clk);
    t_reset_state();
    t_seams_unqualified();
    t_overlay_toggle();
    t_sweep(1'b0, "sweep_rom_R6");
    t_sweep(1'b1, "sweep_ram_R6");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule